// File: doc/BRIEF.md
# Multi-Rail NULL/DATA Completion Detector

This block watches a bundle of NULL-convention signal groups and reports when a whole result has arrived. Every logical variable in the bundle is carried on a group of rails, and at most one rail of a group should be high. With two rails a group carries one boolean. With four rails it carries two booleans. With three rails it carries a three-valued choice, such as one colour out of three. A group with all rails low is NULL, which means "no value yet". That is a legal state and not a fault.

The block turns this into a clocked view. A `complete` flag goes high once every group holds exactly one set rail. It stays high until every rail of the bundle has gone back to zero, so a result is only counted once and partly filled or partly cleared bundles cannot cause glitches. When the flag rises, the block latches the binary index of each group's set rail and presents it while the flag is high. A group with more than one rail set is illegal. It raises an error flag that stays set until reset.

Each group's data flows out on `value_o`, and `complete_o` acts as the valid qualifier. There is no ready input and no back-pressure. The producer must hold its data rails until it sees `complete_o` high, and it must then return all rails to NULL before it sends the next result. Data that changes without passing through NULL is not taken as a new result.

Top module: `rail_bundle_done`

## Requirements
- R1: While `rst_n` is low at a clock edge, `complete_o` and `error_o` become 0 and `value_o` reads 0.
- R2: If `complete_o` is 0 and every group has exactly one rail set at a clock edge, `complete_o` is 1 after that edge.
- R3: In a mixed state (some groups NULL, others holding data), `complete_o` keeps its previous value, whether it was 0 or 1.
- R4: If `complete_o` is 1 and every rail is 0 at a clock edge, `complete_o` is 0 after that edge.
- R5: Group g's result sits in `value_o[g*VW +: VW]`, where VW = max(1, ceil(log2(rails per group))). The result is the index of the set rail, so rail 0 gives 0 and rail 1 gives 1 (for a two-rail group rail 0 is FALSE and rail 1 is TRUE). It is captured at the edge where `complete_o` rises and held unchanged while `complete_o` stays 1, even if the data rails change.
- R6: While `complete_o` is 0, `value_o` is all zeros.
- R7: A group with two or more rails set at a clock edge sets `error_o` after that edge. `error_o` then stays 1 until reset.
- R8: A group with two or more rails set does not count as holding data, so `complete_o` cannot rise while any group is multi-hot.
- R9: Three-rail groups are supported, with rail 2 decoding to value 2 in a two-bit field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rails_i | input | NUM_GROUPS*RAILS | Rail bundle; group g uses bits [g*RAILS +: RAILS] |
| complete_o | output | 1 | High from the arrival of full data until the bundle is fully NULL |
| value_o | output | NUM_GROUPS*VW | Decoded group indices, valid while complete_o is high |
| error_o | output | 1 | Sticky flag for a multi-hot group |

## Verification
On every cycle, the assertions check the edge rules of the completion flag. It must rise after full data and fall after full NULL, and it may never change in any other way. They also check that the decoded value is zero while the flag is low and frozen while it is high, and that the error flag sets on a multi-hot group and never clears by itself. Only the bench scenarios can show that the latched numbers are the right indices for specific rail patterns. The same goes for holding the flag through partial fill and partial clear, and for ignoring data that changes without a NULL in between. The scenarios also cover a multi-hot group that blocks completion, reset clearing the sticky error, and decoding in a three-rail bundle.

// File: rtl/ncl_pkg.sv
package ncl_pkg;
  // Width of the binary index that one rail group decodes to.
  function automatic int val_width(input int rails);
    return (rails > 2) ? $clog2(rails) : 1;
  endfunction
endpackage

// File: rtl/rail_group_decode.sv
module rail_group_decode #(
  parameter int RAILS = 2,
  parameter int VW    = 1
) (
  input  logic [RAILS-1:0] rails_i,
  output logic             is_null_o,
  output logic             is_data_o,
  output logic             is_multi_o,
  output logic [VW-1:0]    idx_o
);
  int ones;

  always_comb begin
    ones = 0;
    idx_o = '0;
    for (int k = 0; k < RAILS; k++) begin
      if (rails_i[k]) begin
        ones = ones + 1;
        idx_o = idx_o | VW'(k);
      end
    end
  end

  assign is_null_o  = (rails_i == '0);
  assign is_data_o  = (ones == 1);
  assign is_multi_o = (ones > 1);
endmodule

// File: rtl/completion_hyst.sv
module completion_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic all_data_i,
  input  logic all_null_i,
  output logic complete_o,
  output logic launch_o
);
  logic done_q;

  assign launch_o   = all_data_i & ~done_q;
  assign complete_o = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     done_q <= 1'b0;
    else if (launch_o)              done_q <= 1'b1;
    else if (done_q && all_null_i)  done_q <= 1'b0;
  end
endmodule

// File: rtl/rail_bundle_done.sv
module rail_bundle_done #(
  parameter int NUM_GROUPS = 4,
  parameter int RAILS      = 2
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic [NUM_GROUPS*RAILS-1:0]                      rails_i,
  output logic                                             complete_o,
  output logic [NUM_GROUPS*ncl_pkg::val_width(RAILS)-1:0]  value_o,
  output logic                                             error_o
);
  localparam int VW    = ncl_pkg::val_width(RAILS);
  localparam int OUT_W = NUM_GROUPS * VW;

  logic [NUM_GROUPS-1:0] grp_null, grp_data, grp_multi;
  logic [OUT_W-1:0]      idx_flat;
  logic [OUT_W-1:0]      val_q;
  logic                  err_q;
  logic                  launch;
  logic                  done;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    rail_group_decode #(.RAILS(RAILS), .VW(VW)) u_dec (
      .rails_i   (rails_i[g*RAILS +: RAILS]),
      .is_null_o (grp_null[g]),
      .is_data_o (grp_data[g]),
      .is_multi_o(grp_multi[g]),
      .idx_o     (idx_flat[g*VW +: VW])
    );
  end

  completion_hyst u_hyst (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_data_i(&grp_data),
    .all_null_i(&grp_null),
    .complete_o(done),
    .launch_o  (launch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (launch) val_q <= idx_flat;
      err_q <= err_q | (|grp_multi);
    end
  end

  assign complete_o = done;
  assign value_o    = done ? val_q : '0;
  assign error_o    = err_q;
endmodule

// File: rtl/rail_bundle_done_chk.sv
module rail_bundle_done_chk #(
  parameter int NUM_GROUPS = 4,
  parameter int RAILS      = 2,
  parameter int OUT_W      = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_GROUPS*RAILS-1:0] rails_i,
  input logic                        complete_o,
  input logic [OUT_W-1:0]            value_o,
  input logic                        error_o
);
  logic [NUM_GROUPS-1:0] one_hot, many;
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_c
    assign one_hot[g] = $onehot(rails_i[g*RAILS +: RAILS]);
    assign many[g]    = ($countones(rails_i[g*RAILS +: RAILS]) > 1);
  end
  wire full = &one_hot;
  wire none = (rails_i == '0);

  a_r2_rise_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!complete_o && full) |=> complete_o);
  a_r4_fall_on_null: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_o && none) |=> !complete_o);
  // R3, R8: a rise needs full legal data, a fall needs full NULL
  a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(complete_o) |-> $past(full));
  a_r3_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(complete_o) |-> $past(none));
  a_r6_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !complete_o |-> (value_o == '0));
  a_r5_value_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_o && $past(complete_o)) |-> $stable(value_o));
  a_r7_error_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|many) |=> error_o);
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o);
endmodule

bind rail_bundle_done rail_bundle_done_chk #(
  .NUM_GROUPS(NUM_GROUPS), .RAILS(RAILS), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rails_i(rails_i),
  .complete_o(complete_o), .value_o(value_o), .error_o(error_o)
);

// File: tb/sim_rail_bundle_done.sv
module sim_rail_bundle_done;
  localparam int G = 4;
  localparam int R = 2;

  typedef struct {
    logic         comp;
    logic         err;
    logic [G-1:0] val;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [G*R-1:0] rails = '0;
  logic complete;
  logic [G-1:0] value;
  logic error;

  logic [5:0] rails3 = '0;
  logic complete3;
  logic [3:0] value3;
  logic error3;

  int checks = 0;
  int errors = 0;
  item_t q[$];

  // model state
  logic m_comp = 1'b0, m_err = 1'b0;
  logic [G-1:0] m_cap = '0;

  always #2.5 clk = ~clk;

  rail_bundle_done #(.NUM_GROUPS(G), .RAILS(R)) u0 (
    .clk(clk), .rst_n(rst_n), .rails_i(rails),
    .complete_o(complete), .value_o(value), .error_o(error));

  rail_bundle_done #(.NUM_GROUPS(2), .RAILS(3)) u1 (
    .clk(clk), .rst_n(rst_n), .rails_i(rails3),
    .complete_o(complete3), .value_o(value3), .error_o(error3));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: apply one rail pattern for one cycle and predict the result
  task automatic drive(input logic [G*R-1:0] r, input string tag);
    item_t it;
    logic full, none, multi;
    logic [G-1:0] dec;
    @(negedge clk);
    rails = r;
    full = 1'b1; multi = 1'b0;
    none = (r == '0);
    for (int g = 0; g < G; g++) begin
      logic [1:0] p;
      p = r[g*R +: R];
      if (p != 2'b01 && p != 2'b10) full = 1'b0;
      if (p == 2'b11) multi = 1'b1;
      dec[g] = p[1];
    end
    if (!m_comp && full) begin m_comp = 1'b1; m_cap = dec; end
    else if (m_comp && none) m_comp = 1'b0;
    m_err = m_err | multi;
    it.comp = m_comp; it.err = m_err;
    it.val = m_comp ? m_cap : '0;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({it.tag, " complete"}, 32'(complete), 32'(it.comp));
      check({it.tag, " value"},    32'(value),    32'(it.val));
      check({it.tag, " error"},    32'(error),    32'(it.err));
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 complete", 32'(complete), 0);
    check("R1 value", 32'(value), 0);
    check("R1 error", 32'(error), 0);
    rst_n = 1'b1;
    // groups: g0=T g1=F g2=T g3=F -> value 4'b0101
    drive(8'b00_00_00_00, "R6 idle");
    drive(8'b00_00_01_10, "R3 partial fill");
    drive(8'b01_10_01_10, "R2 full data");
    drive(8'b01_10_01_10, "R5 held");
    drive(8'b00_10_00_10, "R3 partial clear");
    drive(8'b10_01_10_01, "R5 change without null");
    drive(8'b00_00_00_00, "R4 full null");
    drive(8'b00_00_00_00, "R6 stays idle");
    drive(8'b10_10_10_10, "R2 all true");
    drive(8'b00_00_00_00, "R4 clear");
    drive(8'b01_01_01_11, "R8 multi-hot blocks");
    drive(8'b01_01_01_01, "R7 sticky");
    drive(8'b00_00_00_00, "R7 sticky null");
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 error cleared", 32'(error), 0);
    check("R1 complete cleared", 32'(complete), 0);
    rst_n = 1'b1;
    // three-rail bundle: g0 rail2, g1 rail1 -> {2'd1, 2'd2}
    rails3 = 6'b010_100;
    @(negedge clk);
    check("R9 complete", 32'(complete3), 1);
    check("R9 value", 32'(value3), 32'h6);
    rails3 = 6'b000_000;
    @(negedge clk);
    check("R9 null", 32'(complete3), 0);
    check("R9 error", 32'(error3), 0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule